// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block lives in the execute stage of a five-stage, single-issue integer pipeline. It compares the two source register numbers of the instruction in execute against the destination register numbers of the two instructions ahead of it. One of those instructions sits in the memory stage and the other in the writeback stage. From that comparison it builds a select code for each ALU operand and drives two three-way operand multiplexers. Each operand can come from the register file, the memory stage's ALU result, or the writeback stage's result.

It also covers a load followed at once by a store of the loaded register. In that case the store reaches the memory stage while the load sits in writeback, and a third select swaps the loaded data in as the store's write data. The whole block is combinational. Stalls for load-use hazards, branches and the register file are handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage writes a register matching a source, that source's select is 0 and the operand equals the register-file value for it.
- R2: When the memory stage has its write enable set and its destination equals a nonzero Rs, selA is 2 and opA equals the memory-stage ALU result.
- R3: When the memory stage has its write enable set and its destination equals a nonzero Rt, selB is 2 and opB equals the memory-stage ALU result.
- R4: When only the writeback stage writes a register matching a nonzero source, that source's select is 1 and the operand equals the writeback value.
- R5: When both later stages write the register a source reads, the memory-stage (newer) result is chosen, with select 2.
- R6: A source register number of 0 never forwards. Its select stays 0 even when a later stage writes register 0.
- R7: A stage whose write enable is clear is ignored, even if its destination matches a source.
- R8: The writeback value is the loaded data when wbIsLoad is 1, and the writeback ALU result otherwise.
- R9: When the memory stage holds a store (memIsStore=1) whose data register is nonzero and equals the destination of a writing load in writeback, storeSel is 1 and storeData equals the writeback loaded data.
- R10: In every other case, storeSel is 0 and storeData equals the store data carried by the memory stage. This includes a non-load producer, a store data register of 0, or no store.
- R11: Both operands may forward from the same producer in the same cycle, each select being decided on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRs | input | 5 | First source register of the instruction in execute |
| exRt | input | 5 | Second source register of the instruction in execute |
| rfDataA | input | 32 | Register-file value read for exRs |
| rfDataB | input | 32 | Register-file value read for exRt |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| memDest | input | 5 | Memory-stage destination register |
| memAluResult | input | 32 | Memory-stage ALU result |
| memIsStore | input | 1 | Memory-stage instruction is a store |
| memStoreSrc | input | 5 | Register number of the store's data |
| memStoreData | input | 32 | Store data carried from execute |
| wbRegWrite | input | 1 | Writeback-stage instruction writes a register |
| wbDest | input | 5 | Writeback-stage destination register |
| wbIsLoad | input | 1 | Writeback-stage instruction is a load |
| wbAluResult | input | 32 | Writeback-stage ALU result |
| wbLoadData | input | 32 | Writeback-stage loaded data |
| opA | output | 32 | First ALU operand |
| opB | output | 32 | Second ALU operand |
| storeData | output | 32 | Data-memory write data |
| selA | output | 2 | First operand select (0 regfile, 1 writeback, 2 memory) |
| selB | output | 2 | Second operand select (0 regfile, 1 writeback, 2 memory) |
| storeSel | output | 1 | 1 when store data is taken from writeback load data |

## Verification
The assertions assume every input is a known value. They only evaluate once no input carries X or Z, because a combinational comparison of unknown register numbers says nothing. They also assume the pipeline control is consistent: a stage marked as a load also has its write enable set. The stimulus drives every input to a defined value in each cycle and pairs wbIsLoad only with wbRegWrite set, so the register-zero and disabled-write cases are exercised only on purpose.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SEL_REGFILE = 2'd0,
    SEL_WB      = 2'd1,
    SEL_MEM     = 2'd2
  } fwdSel_t;

  typedef struct packed {
    fwdSel_t selA;
    fwdSel_t selB;
    logic    storeFwd;
  } fwdCtl_t;

endpackage

// File: rtl/fwd_control.sv
module fwd_control
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] memDest,
  input  logic             memIsStore,
  input  logic [REG_W-1:0] memStoreSrc,
  input  logic             wbRegWrite,
  input  logic [REG_W-1:0] wbDest,
  input  logic             wbIsLoad,
  output fwdCtl_t          ctl
);

  localparam int NUM_SRC = 2;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [REG_W-1:0] srcReg [NUM_SRC];
  fwdSel_t          srcSel [NUM_SRC];

  assign srcReg[0] = exRs;
  assign srcReg[1] = exRt;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic hitMem;
    logic hitWb;
    assign hitMem = memRegWrite && (memDest == srcReg[g]) && (srcReg[g] != ZERO_REG);
    assign hitWb  = wbRegWrite  && (wbDest  == srcReg[g]) && (srcReg[g] != ZERO_REG);
    always_comb begin
      if (hitMem)     srcSel[g] = SEL_MEM;
      else if (hitWb) srcSel[g] = SEL_WB;
      else            srcSel[g] = SEL_REGFILE;
    end
  end

  logic storeHit;
  assign storeHit = memIsStore && wbRegWrite && wbIsLoad &&
                    (memStoreSrc != ZERO_REG) && (memStoreSrc == wbDest);

  always_comb begin
    ctl.selA     = srcSel[0];
    ctl.selB     = srcSel[1];
    ctl.storeFwd = storeHit;
  end

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdCtl_t          ctl,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [DATA_W-1:0] memAluResult,
  input  logic             wbIsLoad,
  input  logic [DATA_W-1:0] wbAluResult,
  input  logic [DATA_W-1:0] wbLoadData,
  input  logic [DATA_W-1:0] memStoreData,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] storeData
);

  localparam int NUM_SRC = 2;

  logic [DATA_W-1:0] wbValue;
  logic [DATA_W-1:0] rfIn  [NUM_SRC];
  logic [DATA_W-1:0] opOut [NUM_SRC];
  fwdSel_t           sel   [NUM_SRC];

  assign wbValue = wbIsLoad ? wbLoadData : wbAluResult;

  assign rfIn[0] = rfDataA;
  assign rfIn[1] = rfDataB;
  assign sel[0]  = ctl.selA;
  assign sel[1]  = ctl.selB;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mux
    always_comb begin
      unique case (sel[g])
        SEL_MEM: opOut[g] = memAluResult;
        SEL_WB:  opOut[g] = wbValue;
        default: opOut[g] = rfIn[g];
      endcase
    end
  end

  assign opA       = opOut[0];
  assign opB       = opOut[1];
  assign storeData = ctl.storeFwd ? wbLoadData : memStoreData;

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  exRs,
  input  logic [REG_W-1:0]  exRt,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic              memRegWrite,
  input  logic [REG_W-1:0]  memDest,
  input  logic [DATA_W-1:0] memAluResult,
  input  logic              memIsStore,
  input  logic [REG_W-1:0]  memStoreSrc,
  input  logic [DATA_W-1:0] memStoreData,
  input  logic              wbRegWrite,
  input  logic [REG_W-1:0]  wbDest,
  input  logic              wbIsLoad,
  input  logic [DATA_W-1:0] wbAluResult,
  input  logic [DATA_W-1:0] wbLoadData,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] storeData,
  output logic [1:0]        selA,
  output logic [1:0]        selB,
  output logic              storeSel
);

  fwdCtl_t ctl;

  fwd_control #(.REG_W(REG_W)) i_control (
    .exRs(exRs), .exRt(exRt),
    .memRegWrite(memRegWrite), .memDest(memDest),
    .memIsStore(memIsStore), .memStoreSrc(memStoreSrc),
    .wbRegWrite(wbRegWrite), .wbDest(wbDest), .wbIsLoad(wbIsLoad),
    .ctl(ctl)
  );

  fwd_datapath #(.DATA_W(DATA_W)) i_datapath (
    .ctl(ctl),
    .rfDataA(rfDataA), .rfDataB(rfDataB),
    .memAluResult(memAluResult),
    .wbIsLoad(wbIsLoad), .wbAluResult(wbAluResult), .wbLoadData(wbLoadData),
    .memStoreData(memStoreData),
    .opA(opA), .opB(opB), .storeData(storeData)
  );

  assign selA     = ctl.selA;
  assign selB     = ctl.selB;
  assign storeSel = ctl.storeFwd;

endmodule

// File: rtl/fwd_unit_checker.sv
module fwd_unit_checker #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_W-1:0]  exRs,
  input logic [REG_W-1:0]  exRt,
  input logic [DATA_W-1:0] rfDataA,
  input logic              memRegWrite,
  input logic [REG_W-1:0]  memDest,
  input logic [DATA_W-1:0] memAluResult,
  input logic [DATA_W-1:0] memStoreData,
  input logic              wbRegWrite,
  input logic [REG_W-1:0]  wbDest,
  input logic              wbIsLoad,
  input logic [DATA_W-1:0] wbAluResult,
  input logic [DATA_W-1:0] wbLoadData,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] storeData,
  input logic [1:0]        selA,
  input logic [1:0]        selB,
  input logic              storeSel
);

  logic known;
  assign known = !$isunknown({exRs, exRt, memRegWrite, memDest, wbRegWrite,
                              wbDest, wbIsLoad, selA, selB, storeSel});

  always_comb begin
    if (known) begin
      // R1: register-file select passes the register-file value
      a_r1_regfile_pass: assert (selA != 2'd0 || opA == rfDataA);
      // R2: memory-stage select delivers memory ALU result
      a_r2_mem_to_opa: assert (selA != 2'd2 || opA == memAluResult);
      // R3
      a_r3_mem_to_opb: assert (selB != 2'd2 || opB == memAluResult);
      // R5: newer stage wins on a double write
      a_r5_newer_wins: assert (!(memRegWrite && memDest == exRs && exRs != '0) || selA == 2'd2);
      // R6: register zero is never forwarded
      a_r6_zero_rs: assert (exRs != '0 || selA == 2'd0);
      a_r6_zero_rt: assert (exRt != '0 || selB == 2'd0);
      // R7: no writers, no forwarding
      a_r7_no_writer: assert (memRegWrite || wbRegWrite || (selA == 2'd0 && selB == 2'd0));
      // R8: writeback select delivers the right writeback value
      a_r8_wb_value: assert (selA != 2'd1 || opA == (wbIsLoad ? wbLoadData : wbAluResult));
      // R9 / R10: store data path follows storeSel
      a_r9_store_fwd: assert (!storeSel || storeData == wbLoadData);
      a_r10_store_keep: assert (storeSel || storeData == memStoreData);
      a_r9_store_needs_load: assert (!storeSel || (wbIsLoad && wbRegWrite));
    end
  end

endmodule

bind fwd_unit fwd_unit_checker #(.REG_W(REG_W), .DATA_W(DATA_W)) i_checker (
  .exRs(exRs), .exRt(exRt), .rfDataA(rfDataA),
  .memRegWrite(memRegWrite), .memDest(memDest), .memAluResult(memAluResult),
  .memStoreData(memStoreData),
  .wbRegWrite(wbRegWrite), .wbDest(wbDest), .wbIsLoad(wbIsLoad),
  .wbAluResult(wbAluResult), .wbLoadData(wbLoadData),
  .opA(opA), .opB(opB), .storeData(storeData),
  .selA(selA), .selB(selB), .storeSel(storeSel)
);

// File: tb/test_fwd_unit.sv
module test_fwd_unit;

  localparam logic [31:0] RF_A   = 32'h1111_0000;
  localparam logic [31:0] RF_B   = 32'h2222_0000;
  localparam logic [31:0] MEM_AL = 32'hAAAA_0001;
  localparam logic [31:0] WB_AL  = 32'hBBBB_0002;
  localparam logic [31:0] WB_LD  = 32'hCCCC_0003;
  localparam logic [31:0] ST_DAT = 32'hDDDD_0004;

  typedef struct {
    logic [31:0] opA, opB, st;
    logic [1:0]  selA, selB;
    logic        stSel;
    string       tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [4:0]  exRs, exRt, memDest, memStoreSrc, wbDest;
  logic [31:0] rfDataA, rfDataB, memAluResult, memStoreData, wbAluResult, wbLoadData;
  logic        memRegWrite, memIsStore, wbRegWrite, wbIsLoad;
  logic [31:0] opA, opB, storeData;
  logic [1:0]  selA, selB;
  logic        storeSel;

  fwd_unit i_fwd_unit (
    .exRs(exRs), .exRt(exRt), .rfDataA(rfDataA), .rfDataB(rfDataB),
    .memRegWrite(memRegWrite), .memDest(memDest), .memAluResult(memAluResult),
    .memIsStore(memIsStore), .memStoreSrc(memStoreSrc), .memStoreData(memStoreData),
    .wbRegWrite(wbRegWrite), .wbDest(wbDest), .wbIsLoad(wbIsLoad),
    .wbAluResult(wbAluResult), .wbLoadData(wbLoadData),
    .opA(opA), .opB(opB), .storeData(storeData),
    .selA(selA), .selB(selB), .storeSel(storeSel)
  );

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Expected select from the requirements: memory stage first, then writeback, never reg 0.
  function automatic logic [1:0] modelSel(input logic [4:0] src, input logic mW,
      input logic [4:0] mD, input logic wW, input logic [4:0] wD);
    if (src == 5'd0) return 2'd0;
    if (mW && mD == src) return 2'd2;
    if (wW && wD == src) return 2'd1;
    return 2'd0;
  endfunction

  task automatic apply(input logic [4:0] rs, input logic [4:0] rt,
      input logic mW, input logic [4:0] mD, input logic mSt, input logic [4:0] mSs,
      input logic wW, input logic [4:0] wD, input logic wL, input string tag);
    expItem_t e;
    logic [31:0] wbv;
    @(posedge clk);
    #1;
    exRs = rs; exRt = rt; memRegWrite = mW; memDest = mD; memIsStore = mSt;
    memStoreSrc = mSs; wbRegWrite = wW; wbDest = wD; wbIsLoad = wL;
    wbv = wL ? WB_LD : WB_AL;
    e.selA = modelSel(rs, mW, mD, wW, wD);
    e.selB = modelSel(rt, mW, mD, wW, wD);
    e.opA  = (e.selA == 2'd2) ? MEM_AL : (e.selA == 2'd1) ? wbv : RF_A;
    e.opB  = (e.selB == 2'd2) ? MEM_AL : (e.selB == 2'd1) ? wbv : RF_B;
    e.stSel = mSt && wW && wL && (mSs != 5'd0) && (mSs == wD);
    e.st   = e.stSel ? WB_LD : ST_DAT;
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compares half a cycle after each drive.
  always @(negedge clk) begin
    if (!rst && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      chk({30'd0, selA}, {30'd0, e.selA}, {e.tag, " selA"});
      chk({30'd0, selB}, {30'd0, e.selB}, {e.tag, " selB"});
      chk(opA, e.opA, {e.tag, " opA"});
      chk(opB, e.opB, {e.tag, " opB"});
      chk({31'd0, storeSel}, {31'd0, e.stSel}, {e.tag, " storeSel"});
      chk(storeData, e.st, {e.tag, " storeData"});
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exRs = '0; exRt = '0; memRegWrite = 0; memDest = '0; memIsStore = 0;
    memStoreSrc = '0; wbRegWrite = 0; wbDest = '0; wbIsLoad = 0;
    rfDataA = RF_A; rfDataB = RF_B; memAluResult = MEM_AL; memStoreData = ST_DAT;
    wbAluResult = WB_AL; wbLoadData = WB_LD;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset idle");
    apply(3, 4, 1, 7, 0, 0, 1, 8, 0, "R1 no dependency");
    apply(2, 5, 1, 2, 0, 0, 0, 0, 0, "R2 mem match rs");
    apply(6, 2, 1, 2, 0, 0, 0, 0, 0, "R3 mem match rt");
    apply(2, 5, 0, 0, 0, 0, 1, 2, 0, "R4 wb match rs alu");
    apply(6, 2, 1, 9, 0, 0, 1, 2, 0, "R4 wb match rt alu");
    apply(2, 9, 0, 0, 0, 0, 1, 2, 1, "R8 wb load value");
    apply(1, 1, 1, 1, 0, 0, 1, 1, 0, "R5 double write");
    apply(4, 4, 1, 4, 0, 0, 1, 4, 1, "R5 double write load older");
    apply(0, 0, 1, 0, 0, 0, 1, 0, 0, "R6 zero reg");
    apply(0, 3, 1, 0, 0, 0, 1, 3, 0, "R6 zero rs only");
    apply(2, 2, 0, 2, 0, 0, 0, 2, 0, "R7 writes disabled");
    apply(2, 3, 0, 2, 0, 0, 1, 3, 0, "R7 mem disabled wb used");
    apply(2, 2, 1, 2, 0, 0, 0, 0, 0, "R11 both from mem");
    apply(7, 7, 0, 0, 0, 0, 1, 7, 1, "R11 both from wb");
    apply(0, 0, 0, 0, 1, 5, 1, 5, 1, "R9 load then store");
    apply(0, 0, 0, 0, 1, 5, 1, 5, 0, "R10 non-load producer");
    apply(0, 0, 0, 0, 1, 0, 1, 0, 1, "R10 store reg zero");
    apply(0, 0, 0, 0, 0, 5, 1, 5, 1, "R10 not a store");
    apply(0, 0, 0, 0, 1, 6, 1, 5, 1, "R10 reg mismatch");
    apply(0, 0, 0, 0, 1, 5, 0, 5, 0, "R10 wb not writing");
    for (int i = 0; i < 64; i++) begin
      logic [4:0] a, b, m, w;
      a = 5'(i * 7); b = 5'(i * 3 + 1); m = 5'(i % 5); w = 5'(i % 3);
      apply(a, b, 1'(i), m, 1'(i >> 1), w, 1'(i >> 2), w, 1'(i >> 2), "R5 sweep");
    end
    @(posedge clk);
    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule